// File: doc/BRIEF.md
# Wake-up Magic Packet Detector

This block sits on the receive path next to a MAC. It watches the bytes of an incoming Ethernet frame and raises a single-cycle flag when the frame is a wake-up packet. The frame qualifies in two separate steps.

The first step is a destination filter. By default the first six bytes must equal the station's programmed 48-bit address. A relaxed mode instead accepts any unicast, multicast or broadcast destination. Two independent enable inputs control this mode, and either one turns it on.

The second step checks the payload, and it applies whatever the destination was. Somewhere after the destination field, the payload must hold a run of six 0xFF bytes followed at once by sixteen back-to-back copies of the station's own address. The result is reported only when the frame closes normally.

Top module: `wake_pkt_detect`

## Requirements
- R1: While reset is high, and in the cycle after it is released, `wake_pulse` is low, and all frame state is cleared.
- R2: With both relax inputs low, a frame can be reported only if its bytes 0..5 equal the station address sent least significant byte first (byte 0 = `station_addr[7:0]`, byte 5 = `station_addr[47:40]`).
- R3: With the relaxed mode on, a frame whose destination is broadcast (all 0xFF), multicast or another unicast address is reported when its payload is otherwise valid.
- R4: The payload must contain 16 consecutive copies of the station address. Each copy is sent least significant byte first. Fifteen copies, or copies in most-significant-first order, give no report.
- R5: The relaxed mode is the OR of `relax_a` and `relax_b`, and either input alone is enough.
- R6: Even in relaxed mode, the repeated payload pattern must be the station address. Repeating the frame's destination address instead gives no report.
- R7: The copies must follow at least six consecutive 0xFF bytes. Fewer than six, or any mismatching byte inside the pattern, restarts the search. A later complete pattern in the same frame still counts.
- R8: A report is a one-cycle pulse in the cycle after the byte marked end of frame is accepted. A frame ended by `frame_abort` gives no pulse.
- R9: The pattern may start at any payload offset after the six destination bytes, including after filler bytes.
- R10: A start-of-frame byte re-arms the detector, so each frame is judged on its own bytes only.
- R11: A pattern whose last address byte is itself the end-of-frame byte is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld | input | 1 | A receive byte is present this cycle |
| byte_sof | input | 1 | The present byte is the first byte of a frame |
| byte_eof | input | 1 | The present byte is the last byte of a frame |
| byte_data | input | 8 | Receive byte |
| frame_abort | input | 1 | The frame in progress ends abnormally |
| station_addr | input | 48 | Programmed station address |
| relax_a | input | 1 | First relaxed-destination enable |
| relax_b | input | 1 | Second relaxed-destination enable |
| wake_pulse | output | 1 | One-cycle wake-up detection |

## Verification
Two events can fall in the same cycle: the pattern matcher completing its 96th address byte, and the frame-end decision. The bench provokes this by sending a frame whose final address byte carries the end-of-frame mark. It expects the pulse in the very next cycle, which shows the decision used the matcher's next state and not its registered state. A second collision, a complete pattern followed by an abort in place of an end mark, must give no pulse. The frame sent after it must still be detected.

// File: rtl/wpd_pkg.sv
package wpd_pkg;

    localparam int unsigned WPD_ADDR_BYTES = 6;
    localparam int unsigned WPD_SYNC_LEN   = 6;
    localparam int unsigned WPD_REPS       = 16;

    typedef enum logic [1:0] {
        SEQ_SYNC = 2'd0,
        SEQ_ADDR = 2'd1,
        SEQ_DONE = 2'd2
    } seq_phase_e;

    typedef struct packed {
        logic       vld;
        logic       sof;
        logic       eof;
        logic [7:0] data;
    } rx_byte_t;

    function automatic logic [7:0] addr_byte(input logic [47:0] addr, input int unsigned idx);
        return addr[8*idx +: 8];
    endfunction

endpackage

// File: rtl/wpd_addr_filter.sv
module wpd_addr_filter
    import wpd_pkg::*;
#(
    parameter int unsigned ADDR_BYTES = WPD_ADDR_BYTES
) (
    input  logic                    clk,
    input  logic                    rst,
    input  rx_byte_t                rx,
    input  logic                    abort,
    input  logic [8*ADDR_BYTES-1:0] station_addr,
    output logic                    payload_vld,
    output logic                    da_match
);
    localparam int unsigned IDX_W = $clog2(ADDR_BYTES + 1);
    localparam logic [IDX_W-1:0] DA_LEN = IDX_W'(ADDR_BYTES);

    logic             in_frame;
    logic [IDX_W-1:0] idx;
    logic             da_ok;
    logic [IDX_W-1:0] sel;
    logic             byte_eq;
    logic             start;

    assign start   = rx.vld && rx.sof;
    assign sel     = (idx == DA_LEN) ? '0 : idx;
    assign byte_eq = (rx.data == station_addr[8*sel +: 8]);

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame <= 1'b0;
            idx      <= '0;
            da_ok    <= 1'b0;
        end else if (abort) begin
            in_frame <= 1'b0;
        end else if (start) begin
            in_frame <= !rx.eof;
            idx      <= IDX_W'(1);
            da_ok    <= (rx.data == station_addr[7:0]);
        end else if (rx.vld && in_frame) begin
            if (idx != DA_LEN) begin
                idx   <= idx + IDX_W'(1);
                da_ok <= da_ok && byte_eq;
            end
            if (rx.eof) in_frame <= 1'b0;
        end
    end

    assign payload_vld = rx.vld && !rx.sof && in_frame && (idx == DA_LEN) && !abort;
    assign da_match    = da_ok;

    assert_sof_opens_R10: assert property (@(posedge clk) disable iff (rst)
        (start && !rx.eof && !abort) |=> in_frame);

    assert_abort_closes_R8: assert property (@(posedge clk) disable iff (rst)
        abort |=> !payload_vld);

endmodule

// File: rtl/wpd_pattern_seq.sv
module wpd_pattern_seq
    import wpd_pkg::*;
#(
    parameter int unsigned ADDR_BYTES = WPD_ADDR_BYTES,
    parameter int unsigned SYNC_LEN   = WPD_SYNC_LEN,
    parameter int unsigned REPS       = WPD_REPS
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    restart,
    input  logic                    scan_vld,
    input  logic [7:0]              scan_byte,
    input  logic [8*ADDR_BYTES-1:0] station_addr,
    output logic                    hit_next
);
    localparam int unsigned CNT_W     = $clog2(SYNC_LEN + 1);
    localparam int unsigned REP_BYTES = REPS * ADDR_BYTES;
    localparam int unsigned REP_W     = $clog2(REP_BYTES + 1);
    localparam int unsigned POS_W     = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
    localparam logic [CNT_W-1:0] SYNC_FULL = CNT_W'(SYNC_LEN);
    localparam logic [REP_W-1:0] REP_LAST  = REP_W'(REP_BYTES - 1);
    localparam logic [POS_W-1:0] POS_LAST  = POS_W'(ADDR_BYTES - 1);

    seq_phase_e       phase, phase_n;
    logic [CNT_W-1:0] ff_cnt, ff_cnt_n;
    logic [REP_W-1:0] rep, rep_n;
    logic [POS_W-1:0] pos, pos_n;
    logic             is_ff;
    logic [7:0]       want;

    assign is_ff = (scan_byte == 8'hFF);
    assign want  = station_addr[8*pos +: 8];

    always_comb begin
        phase_n  = phase;
        ff_cnt_n = ff_cnt;
        rep_n    = rep;
        pos_n    = pos;
        if (restart) begin
            phase_n  = SEQ_SYNC;
            ff_cnt_n = '0;
            rep_n    = '0;
            pos_n    = '0;
        end else if (scan_vld) begin
            unique case (phase)
                SEQ_SYNC: begin
                    if (ff_cnt == SYNC_FULL && scan_byte == addr_byte(station_addr, 0)) begin
                        phase_n = SEQ_ADDR;
                        rep_n   = REP_W'(1);
                        pos_n   = (POS_LAST == '0) ? '0 : POS_W'(1);
                    end else if (is_ff) begin
                        ff_cnt_n = (ff_cnt == SYNC_FULL) ? ff_cnt : ff_cnt + CNT_W'(1);
                    end else begin
                        ff_cnt_n = '0;
                    end
                end
                SEQ_ADDR: begin
                    if (scan_byte == want) begin
                        rep_n = rep + REP_W'(1);
                        pos_n = (pos == POS_LAST) ? '0 : pos + POS_W'(1);
                        if (rep == REP_LAST) phase_n = SEQ_DONE;
                    end else begin
                        phase_n  = SEQ_SYNC;
                        ff_cnt_n = is_ff ? CNT_W'(1) : '0;
                        rep_n    = '0;
                        pos_n    = '0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= SEQ_SYNC;
            ff_cnt <= '0;
            rep    <= '0;
            pos    <= '0;
        end else begin
            phase  <= phase_n;
            ff_cnt <= ff_cnt_n;
            rep    <= rep_n;
            pos    <= pos_n;
        end
    end

    assign hit_next = (phase_n == SEQ_DONE);

    assert_rearm_clears_R10: assert property (@(posedge clk) disable iff (rst)
        restart |=> (phase == SEQ_SYNC && ff_cnt == '0));

    assert_done_from_byte_R4: assert property (@(posedge clk) disable iff (rst)
        (phase != SEQ_DONE && !restart) |=> (phase != SEQ_DONE || $past(scan_vld)));

endmodule

// File: rtl/wake_pkt_detect.sv
module wake_pkt_detect
    import wpd_pkg::*;
#(
    parameter int unsigned ADDR_BYTES = WPD_ADDR_BYTES,
    parameter int unsigned SYNC_LEN   = WPD_SYNC_LEN,
    parameter int unsigned REPS       = WPD_REPS
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    byte_vld,
    input  logic                    byte_sof,
    input  logic                    byte_eof,
    input  logic [7:0]              byte_data,
    input  logic                    frame_abort,
    input  logic [8*ADDR_BYTES-1:0] station_addr,
    input  logic                    relax_a,
    input  logic                    relax_b,
    output logic                    wake_pulse
);
    rx_byte_t rx;
    logic     payload_vld;
    logic     da_match;
    logic     hit_next;
    logic     restart;
    logic     relaxed;
    logic     report_d;

    assign rx      = '{vld: byte_vld, sof: byte_sof, eof: byte_eof, data: byte_data};
    assign restart = (byte_vld && byte_sof) || frame_abort;
    assign relaxed = relax_a || relax_b;

    wpd_addr_filter #(.ADDR_BYTES(ADDR_BYTES)) u_filter (
        .clk          (clk),
        .rst          (rst),
        .rx           (rx),
        .abort        (frame_abort),
        .station_addr (station_addr),
        .payload_vld  (payload_vld),
        .da_match     (da_match)
    );

    wpd_pattern_seq #(
        .ADDR_BYTES (ADDR_BYTES),
        .SYNC_LEN   (SYNC_LEN),
        .REPS       (REPS)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .restart      (restart),
        .scan_vld     (payload_vld),
        .scan_byte    (byte_data),
        .station_addr (station_addr),
        .hit_next     (hit_next)
    );

    assign report_d = payload_vld && byte_eof && (relaxed || da_match) && hit_next;

    always_ff @(posedge clk) begin
        if (rst) wake_pulse <= 1'b0;
        else     wake_pulse <= report_d;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> !wake_pulse);

    assert_pulse_single_R8: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |=> !wake_pulse);

    assert_pulse_after_end_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(wake_pulse) |-> $past(byte_vld && byte_eof && !frame_abort));

endmodule

// File: tb/wake_pkt_detect_bench.sv
module wake_pkt_detect_bench;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [47:0] STA = 48'h0A1B_2C3D_4E5F;

    logic        clk = 1'b0;
    logic        rst;
    logic        byte_vld, byte_sof, byte_eof, frame_abort;
    logic [7:0]  byte_data;
    logic [47:0] station_addr;
    logic        relax_a, relax_b;
    logic        wake_pulse;

    int checks = 0;
    int failures = 0;
    logic [7:0] fq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    wake_pkt_detect u_wake_pkt_detect (
        .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_sof(byte_sof),
        .byte_eof(byte_eof), .byte_data(byte_data), .frame_abort(frame_abort),
        .station_addr(station_addr), .relax_a(relax_a), .relax_b(relax_b),
        .wake_pulse(wake_pulse)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic q_addr(input logic [47:0] a, input int n, input bit msb_first);
        for (int k = 0; k < n; k++)
            for (int b = 0; b < 6; b++)
                fq.push_back(msb_first ? a[8*(5-b) +: 8] : a[8*b +: 8]);
    endtask

    task automatic q_fill(input logic [7:0] v, input int n);
        for (int k = 0; k < n; k++) fq.push_back(v);
    endtask

    // mode 0: last byte carries end of frame; mode 1: abort replaces the end mark
    task automatic run_frame(input string req, input int exp, input int mode);
        int pulses = 0;
        int first_after;
        for (int i = 0; i < fq.size(); i++) begin
            @(negedge clk);
            pulses += int'(wake_pulse);
            byte_vld  = 1'b1;
            byte_sof  = (i == 0);
            byte_eof  = (mode == 0) && (i == fq.size() - 1);
            byte_data = fq[i];
        end
        @(negedge clk);
        first_after = int'(wake_pulse);
        pulses += first_after;
        byte_vld = 1'b0; byte_sof = 1'b0; byte_eof = 1'b0;
        frame_abort = (mode == 1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            pulses += int'(wake_pulse);
            frame_abort = 1'b0;
        end
        check({req, " pulse count"}, pulses, exp);
        if (exp == 1) check({req, " pulse cycle"}, first_after, 1);
        fq.delete();
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 pulse in reset", int'(wake_pulse), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 pulse after reset", int'(wake_pulse), 0);
    endtask

    task automatic t_exact_da;
        relax_a = 0; relax_b = 0;
        q_addr(STA, 1, 0); q_fill(8'h11, 8); q_fill(8'hFF, 6); q_addr(STA, 16, 0); q_fill(8'h22, 4);
        run_frame("R2 R4 exact destination", 1, 0);
    endtask

    task automatic t_wrong_da;
        q_addr(48'h0A1B_2C3D_4E50, 1, 0); q_fill(8'hFF, 6); q_addr(STA, 16, 0); q_fill(8'h22, 2);
        run_frame("R2 wrong destination strict", 0, 0);
    endtask

    task automatic t_relaxed;
        relax_a = 1; relax_b = 0;
        q_fill(8'hFF, 6); q_fill(8'h33, 6); q_fill(8'hFF, 6); q_addr(STA, 16, 0); q_fill(8'h22, 2);
        run_frame("R3 R5 broadcast relax_a", 1, 0);
        relax_a = 0; relax_b = 1;
        q_addr(48'h0100_005E_0001, 1, 0); q_fill(8'hFF, 6); q_addr(STA, 16, 0); q_fill(8'h22, 2);
        run_frame("R3 R5 multicast relax_b", 1, 0);
        q_addr(48'h0A1B_2C3D_4E50, 1, 0); q_fill(8'hFF, 6); q_addr(STA, 16, 0); q_fill(8'h22, 2);
        run_frame("R3 other unicast relax_b", 1, 0);
    endtask

    task automatic t_payload_must_be_station;
        relax_a = 1; relax_b = 0;
        q_addr(48'h0100_005E_0001, 1, 0); q_fill(8'hFF, 6); q_addr(48'h0100_005E_0001, 16, 0); q_fill(8'h22, 2);
        run_frame("R6 payload repeats destination", 0, 0);
        relax_a = 0;
    endtask

    task automatic t_count_and_order;
        q_addr(STA, 1, 0); q_fill(8'hFF, 6); q_addr(STA, 15, 0); q_fill(8'h22, 6);
        run_frame("R4 fifteen copies", 0, 0);
        q_addr(STA, 1, 0); q_fill(8'hFF, 6); q_addr(STA, 16, 1); q_fill(8'h22, 2);
        run_frame("R4 msb-first copies", 0, 0);
    endtask

    task automatic t_sync;
        q_addr(STA, 1, 0); q_fill(8'h00, 1); q_fill(8'hFF, 5); q_addr(STA, 16, 0); q_fill(8'h22, 2);
        run_frame("R7 five sync bytes", 0, 0);
        q_addr(STA, 1, 0); q_fill(8'hFF, 6); q_addr(STA, 3, 0); q_fill(8'h00, 1);
        q_fill(8'h44, 5); q_fill(8'hFF, 6); q_addr(STA, 16, 0); q_fill(8'h22, 2);
        run_frame("R7 R9 broken then restarted", 1, 0);
        q_addr(STA, 1, 0); q_fill(8'hFF, 6); q_addr(STA, 8, 0); q_fill(8'h5F, 1); q_addr(STA, 8, 0); q_fill(8'h22, 2);
        run_frame("R7 mismatch inside pattern", 0, 0);
    endtask

    task automatic t_abort_and_rearm;
        q_addr(STA, 1, 0); q_fill(8'hFF, 6); q_addr(STA, 16, 0); q_fill(8'h22, 2);
        run_frame("R8 aborted frame", 0, 1);
        q_addr(STA, 1, 0); q_addr(STA, 8, 0); q_fill(8'h22, 1);
        run_frame("R10 partial-only frame after abort", 0, 0);
        q_addr(STA, 1, 0); q_fill(8'hFF, 6); q_addr(STA, 16, 0); q_fill(8'h22, 2);
        run_frame("R10 next frame re-armed", 1, 0);
    endtask

    task automatic t_end_on_last_byte;
        q_addr(STA, 1, 0); q_fill(8'hFF, 6); q_addr(STA, 16, 0);
        run_frame("R11 completion on end byte", 1, 0);
    endtask

    initial begin
        rst = 1'b1; byte_vld = 0; byte_sof = 0; byte_eof = 0; byte_data = 0;
        frame_abort = 0; station_addr = STA; relax_a = 0; relax_b = 0;
        t_reset();
        t_exact_da();
        t_wrong_da();
        t_relaxed();
        t_payload_must_be_station();
        t_count_and_order();
        t_sync();
        t_abort_and_rearm();
        t_end_on_last_byte();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule